// File: doc/BRIEF.md
# Pipelined Serial Converter Host

This block sits on the system side of a serial 8-bit analog-to-digital converter. It drives the converter's chip-select, serial clock and command line, and reads the converter's result line. Control bytes arrive on a valid/ready input. Each accepted byte is shifted out as one conversion frame. The result that belongs to it is shifted back in while the following byte is already going out. Every finished result is presented with a one-cycle strobe and the tag that came with its control byte.

Two frame lengths can be chosen when the block leaves idle. The short frame uses ten serial clocks per conversion. The byte-aligned frame uses sixteen. In both, chip-select stays low for as long as commands keep arriving, because the high first bit of each control byte marks where a frame begins. When the input runs dry, the block keeps clocking only until the last pending result is complete. It then parks the serial clock low and raises chip-select. The serial clock is the system clock divided by an even ratio set from a port. Data leaves on the falling serial edge and is captured on the rising edge.

The result window begins at edge `D7_FAST` (or `D7_BYTE`) of a frame and runs for eight edges into the next frame. For this reason each of these parameters must be below its frame length, and the window must run past the end of the frame.

Top module: `adc_host`

## Requirements
- R1: After reset and while idle, cs_n is 1, sclk is 0, mosi is 0, res_valid is 0 and cmd_ready is 1.
- R2: While running, sclk has a period of 2*max(half_div,1) system clocks and has no gaps between frames. sclk is 0 whenever cs_n is 1.
- R3: With mode_byte=0 latched, a frame lasts 10 rising sclk edges. At edges 1..8 of the frame, mosi carries 1 and then cmd_data bits 6 down to 0, so the start bit is 1 even when cmd_data[7] is 0. At edges 9 and 10, mosi is 0.
- R4: With mode_byte=1 latched, a frame lasts 16 rising sclk edges. Edges 1..8 are used as in R3, and mosi is 0 at edges 9..16.
- R5: In the 10-edge mode, the result of frame k is captured MSB first from miso at edges 8, 9 and 10 of frame k and at edges 1..5 of the next frame.
- R6: In the 16-edge mode, the result of frame k is captured MSB first at edges 12..16 of frame k and at edges 1..3 of the next frame.
- R7: res_valid is a single-cycle pulse. It is high in the system cycle in which sclk goes high for the last result bit, and it carries res_data and the res_tag given with that frame's control byte.
- R8: Outside idle, cmd_ready is high only in the single cycle just before a frame's last rising edge. A byte accepted there starts the next frame without idle clocks, and cs_n stays 0 between the two frames.
- R9: If no byte is accepted at a frame's end, mosi stays 0 and clocking continues through the last result bit's edge. sclk then stops low at the next falling edge, and cs_n rises in the same cycle. No byte is accepted before cs_n is 1.
- R10: mode_byte is sampled only when a frame starts from idle. Changing it during a run has no effect until the next start from idle.
- R11: The first frame after idle yields no result. Each run yields exactly one result per accepted byte, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_byte | input | 1 | 0 selects 10-edge frames, 1 selects 16-edge frames |
| half_div | input | DIV_W | System clocks per sclk half period (0 acts as 1) |
| cmd_valid | input | 1 | Control byte offered |
| cmd_ready | output | 1 | Control byte taken this cycle when valid |
| cmd_data | input | 8 | Control byte; bit 7 is replaced by a 1 on the wire |
| cmd_tag | input | TAG_W | Tag returned with this byte's result |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial command data toward the converter |
| miso | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Conversion result |
| res_tag | output | TAG_W | Tag of the control byte the result belongs to |

## Verification
Counted from the start of a run, the result of frame k is due in the cycle in which sclk rises for edge k*N + D7 + 7. chip-select is due to rise once edge (L-1)*N + D7 + 7 has been seen, where L is the number of bytes in the run. cmd_ready is due only in the cycle before an edge whose number is a multiple of N. A converter model in the bench samples sclk, cs_n, mosi and the result port on the falling system edge and numbers the rising sclk edges itself. It drives miso only from its own edge count, and compares each strobe and edge against those formulas rather than waiting for the outputs. The measured spacing of sclk rises is checked against twice the effective divider for every edge.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
  localparam int CTRL_W = 8;
  localparam int RES_W  = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} seq_state_e;
endpackage

// File: rtl/adc_host_sclk_div.sv
`timescale 1ns/1ps
module adc_host_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_now,
  output logic             fall_now
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_m1;
  logic             wrap;

  assign lim_m1   = (half_div == '0) ? '0 : half_div - DIV_W'(1);
  assign wrap     = run && (cnt >= lim_m1);
  assign rise_now = wrap && !sclk;
  assign fall_now = wrap && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + DIV_W'(1);
    end
  end

  // R2: a stopped divider leaves the serial clock low
  p_sclk_halt_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);
endmodule

// File: rtl/adc_host_rx.sv
`timescale 1ns/1ps
module adc_host_rx
  import adc_host_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sample,
  input  logic             miso,
  input  logic [TAG_W-1:0] tag_in,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [TAG_W-1:0] res_tag
);
  localparam int CW = $clog2(RES_W);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [RES_W-2:0] sh;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      tag_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_tag   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        sh    <= {{(RES_W-2){1'b0}}, miso};
        cnt   <= CW'(1);
        busy  <= 1'b1;
        tag_q <= tag_in;
      end else if (sample && busy) begin
        sh <= {sh[RES_W-3:0], miso};
        if (cnt == CW'(RES_W-1)) begin
          res_valid <= 1'b1;
          res_data  <= {sh, miso};
          res_tag   <= tag_q;
          busy      <= 1'b0;
          cnt       <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R5: a new result window never opens over an unfinished one
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/adc_host_seq.sv
`timescale 1ns/1ps
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int FAST_LEN = 10,
  parameter int BYTE_LEN = 16,
  parameter int D7_FAST  = 8,
  parameter int D7_BYTE  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_byte,
  input  logic              cmd_valid,
  input  logic [CTRL_W-1:0] cmd_data,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              cmd_ready,
  input  logic              rise_now,
  input  logic              fall_now,
  output logic              run,
  output logic              cs_n,
  output logic              mosi,
  output logic              rx_start,
  output logic [TAG_W-1:0]  rx_tag
);
  localparam int EW = $clog2(BYTE_LEN + 1);
  localparam logic [EW-1:0] LEN_F  = EW'(FAST_LEN);
  localparam logic [EW-1:0] LEN_B  = EW'(BYTE_LEN);
  localparam logic [EW-1:0] D7_F   = EW'(D7_FAST);
  localparam logic [EW-1:0] D7_B   = EW'(D7_BYTE);
  localparam logic [EW-1:0] CMD_EN = EW'(CTRL_W);

  seq_state_e        st;
  logic              mode_q;
  logic              nxt_has;
  logic [EW-1:0]     edge_cnt;
  logic [EW-1:0]     edge_nxt;
  logic [EW-1:0]     frame_len;
  logic [EW-1:0]     d7_edge;
  logic [EW-1:0]     drain_last;
  logic [CTRL_W-1:0] tx;
  logic [TAG_W-1:0]  tag_cur;

  assign frame_len  = mode_q ? LEN_B : LEN_F;
  assign d7_edge    = mode_q ? D7_B : D7_F;
  assign drain_last = d7_edge + EW'(RES_W - 1) - frame_len;
  assign edge_nxt   = (edge_cnt == frame_len) ? EW'(1) : edge_cnt + EW'(1);
  assign run        = (st != ST_IDLE);
  assign rx_tag     = tag_cur;
  assign cmd_ready  = (st == ST_IDLE) ||
                      ((st == ST_RUN) && rise_now && (edge_nxt == frame_len));
  assign rx_start   = (st == ST_RUN) && rise_now && (edge_nxt == d7_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= 1'b0;
      nxt_has  <= 1'b0;
      edge_cnt <= '0;
      tx       <= '0;
      tag_cur  <= '0;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            tx       <= {1'b1, cmd_data[CTRL_W-2:0]};
            tag_cur  <= cmd_tag;
            mode_q   <= mode_byte;
            edge_cnt <= '0;
            mosi     <= 1'b1;
            cs_n     <= 1'b0;
            st       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rise_now) begin
            edge_cnt <= edge_nxt;
            if (edge_nxt == frame_len) begin
              nxt_has <= cmd_valid;
              if (cmd_valid) begin
                tx      <= {1'b1, cmd_data[CTRL_W-2:0]};
                tag_cur <= cmd_tag;
              end
            end
          end else if (fall_now) begin
            if (edge_cnt == frame_len) begin
              if (nxt_has) begin
                mosi <= 1'b1;
              end else begin
                mosi     <= 1'b0;
                edge_cnt <= '0;
                st       <= ST_DRAIN;
              end
            end else if (edge_cnt < CMD_EN) begin
              mosi <= tx[CTRL_W-2];
              tx   <= {tx[CTRL_W-2:0], 1'b0};
            end else begin
              mosi <= 1'b0;
            end
          end
        end
        ST_DRAIN: begin
          if (rise_now) begin
            edge_cnt <= edge_cnt + EW'(1);
          end else if (fall_now && (edge_cnt == drain_last)) begin
            edge_cnt <= '0;
            cs_n     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: inside a run the accept slot lasts exactly one cycle
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (run && cmd_ready) |=> !cmd_ready);

  // R3: the command line is low in the padding edges of a running frame
  p_tail_low_r3: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN) && (edge_cnt > CMD_EN) && (edge_cnt < frame_len)) |-> !mosi);

  // R9: while draining, nothing is accepted and the command line is low
  p_drain_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRAIN) |-> (!cmd_ready && !mosi));
endmodule

// File: rtl/adc_host.sv
`timescale 1ns/1ps
module adc_host
  import adc_host_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int TAG_W    = 4,
  parameter int FAST_LEN = 10,
  parameter int BYTE_LEN = 16,
  parameter int D7_FAST  = 8,
  parameter int D7_BYTE  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_byte,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CTRL_W-1:0] cmd_data,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [TAG_W-1:0]  res_tag
);
  logic             run;
  logic             rise_now;
  logic             fall_now;
  logic             rx_start;
  logic [TAG_W-1:0] rx_tag;

  adc_host_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .half_div (half_div),
    .sclk     (sclk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  adc_host_seq #(
    .TAG_W    (TAG_W),
    .FAST_LEN (FAST_LEN),
    .BYTE_LEN (BYTE_LEN),
    .D7_FAST  (D7_FAST),
    .D7_BYTE  (D7_BYTE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mode_byte (mode_byte),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_tag   (cmd_tag),
    .cmd_ready (cmd_ready),
    .rise_now  (rise_now),
    .fall_now  (fall_now),
    .run       (run),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .rx_start  (rx_start),
    .rx_tag    (rx_tag)
  );

  adc_host_rx #(.TAG_W(TAG_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .start     (rx_start),
    .sample    (rise_now),
    .miso      (miso),
    .tag_in    (rx_tag),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_tag   (res_tag)
  );

  // R2: the serial clock rests low whenever chip-select is released
  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R7: the result strobe never lasts two cycles
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

// File: tb/adc_host_tb_top.sv
`timescale 1ns/1ps
module adc_host_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_byte;
  logic [7:0] half_div;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_data;
  logic [3:0] cmd_tag;
  logic       cs_n;
  logic       sclk;
  logic       mosi;
  logic       miso;
  logic       res_valid;
  logic [7:0] res_data;
  logic [3:0] res_tag;

  always #2.5 clk = ~clk;

  adc_host dut_i (
    .clk(clk), .rst(rst), .mode_byte(mode_byte), .half_div(half_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_tag(cmd_tag), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag)
  );

  int checks = 0;
  int fails  = 0;
  int n_sent = 0;
  int rc     = 0;
  logic [7:0] sent_cmd [256];
  logic [7:0] exp_res  [256];
  int  st_mode  = 0;
  int  st_heff  = 1;
  bit  acc_idle = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: samples everything on the falling system edge
  int cyc = 0, g = 0, nb = 10, d7b = 8, bbase = 0, last_rise = -1;
  bit prev_sclk = 1'b0, prev_cs = 1'b1, prev_valid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        g = 0; nb = (st_mode != 0) ? 16 : 10; d7b = (nb == 16) ? 12 : 8;
        bbase = rc; last_rise = -1; miso = 1'b0;
      end
      if (!prev_sclk && sclk) begin
        int pos, fb, idx, e;
        g++;
        pos = (g - 1) % nb + 1;
        fb  = (g - 1) / nb;
        idx = bbase + fb;
        if (last_rise >= 0) chk((cyc - last_rise) == 2 * st_heff, "R2", cyc - last_rise, 2 * st_heff);
        last_rise = cyc;
        if (pos <= 8 && idx < n_sent) e = (pos == 1) ? 1 : int'(sent_cmd[idx][8-pos]);
        else e = 0;
        chk(mosi == e[0], (nb == 10) ? "R3" : "R4", int'(mosi), e);
      end
      if (prev_sclk && !sclk) begin
        int u, o, f, bp;
        u = g + 1;
        miso = u[0];
        if (u >= d7b) begin
          o = u - d7b; f = o / nb; bp = o % nb;
          if (bp < 8 && bbase + f < n_sent) miso = exp_res[bbase+f][7-bp];
        end
      end
      if (res_valid) begin
        int eg;
        eg = (rc - bbase) * nb + d7b + 7;
        chk(res_data == exp_res[rc], (nb == 10) ? "R5" : "R6", int'(res_data), int'(exp_res[rc]));
        chk(res_tag == rc[3:0], "R7", int'(res_tag), rc % 16);
        chk(g == eg && sclk, "R7", g, eg);
        chk(!prev_valid, "R7", int'(prev_valid), 0);
        rc++;
      end
      if (!cs_n && cmd_ready)
        chk(!sclk && (g % nb) == nb - 1, "R8", g % nb, nb - 1);
      if (!prev_cs && cs_n) begin
        int eg;
        eg = (n_sent - bbase - 1) * nb + d7b + 7;
        chk(g == eg, "R9", g, eg);
        chk(!sclk, "R9", int'(sclk), 0);
        chk(rc == n_sent, "R11", rc, n_sent);
      end
      prev_sclk = sclk; prev_cs = cs_n; prev_valid = res_valid;
    end
  end

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = c; cmd_tag = n_sent[3:0];
    while (!cmd_ready) @(negedge clk);
    acc_idle = cs_n;
    if (cs_n) begin
      st_mode = int'(mode_byte);
      st_heff = (half_div == 0) ? 1 : int'(half_div);
    end
    sent_cmd[n_sent] = c;
    exp_res[n_sent]  = 8'((int'(c[6:1]) * 37 + n_sent * 11) & 255);
    @(posedge clk); #1;
    n_sent++;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cs_n && rc == n_sent)) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cmd_ready && !sclk && !mosi, "R1", int'(cmd_ready), 1);
  endtask

  task automatic burst(input int m, input int h, input int len, input bit flip);
    @(negedge clk);
    mode_byte = m[0]; half_div = 8'(h);
    for (int i = 0; i < len; i++) begin
      send(8'((n_sent * 53 + 42) & 255) ^ (i[0] ? 8'h80 : 8'h00));
      if (flip && i == 0) mode_byte = ~m[0]; // R10: late change ignored
    end
    wait_idle();
    mode_byte = m[0];
  endtask

  initial begin
    rst = 1'b1; mode_byte = 1'b0; half_div = 8'd1;
    cmd_valid = 1'b0; cmd_data = '0; cmd_tag = '0; miso = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(cs_n, "R1", int'(cs_n), 1);
    chk(!sclk, "R1", int'(sclk), 0);
    chk(!mosi, "R1", int'(mosi), 0);
    chk(!res_valid, "R1", int'(res_valid), 0);
    chk(cmd_ready, "R1", int'(cmd_ready), 1);
    // R3 R4 R5 R6 R8 R11: sweep of divider, mode and run length
    for (int h = 0; h < 4; h++)
      for (int m = 0; m < 2; m++)
        for (int len = 1; len <= 3; len++)
          burst(m, h, len, 1'b0);
    // R10: mode flipped during a run
    burst(0, 2, 3, 1'b1);
    burst(1, 1, 3, 1'b1);
    // R9: byte offered during drain waits for idle
    @(negedge clk);
    mode_byte = 1'b0; half_div = 8'd2;
    send(8'h5A);
    repeat (2 * 2 * 12) @(negedge clk);
    chk(!cs_n, "R9", int'(cs_n), 0);
    send(8'h33);
    chk(acc_idle, "R9", int'(acc_idle), 1);
    wait_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", rc, n_sent);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule